// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 data cache

This block is a 16 KB, four-way set-associative data cache for a 32-bit physical address space with 4 KB pages and 32-byte lines. The set index and the word select come only from the page-offset bits of the address, and those bits are identical before and after translation. The set is therefore chosen from the untranslated offset in the cycle the request is accepted. The physical page number from the translator is needed only one cycle later, when the four stored tags are compared against it.

A processor-side client presents a word-granular page offset, a read/write flag and write data. In the following cycle it supplies the 20-bit physical page number. The cache answers with a one-cycle response pulse. A miss is serviced over a whole-line port to the next memory level. If the chosen victim is dirty, it is written out first, then the missing line is fetched, installed and, for writes, merged with the new word. While a request is in flight the cache raises `busy` and accepts nothing.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid and `busy`, `resp_valid` and `mem_req` are low. The first access to any address is therefore a miss.
- R2: A physical address is {tag[31:12], set[11:5], word[4:2], byte[1:0]}. `req_woff` carries bits 11:2 and is sampled only in the accepting cycle. `ppn` is used only in the cycle after acceptance, so values on `ppn` during the accepting cycle, and on `req_woff` afterwards, have no effect.
- R3: When a request is accepted at edge k and hits, `resp_valid` is high for exactly the cycle after edge k+1. No memory transfer takes place.
- R4: On a read miss, `mem_req` rises with `mem_we`=0 and `mem_addr` = {ppn, set, 5'b0}. The request is held stable until `mem_ack`. The response follows in the cycle after the acknowledge and returns word[4:2] of the delivered line.
- R5: Writes allocate on a miss: the line is fetched and the word merged into it. A write hit updates only the cache, with no memory transfer. A written line becomes dirty. On a write, `resp_rdata` echoes the written word.
- R6: An invalid way is chosen first, the lowest-numbered such way. Otherwise a 3-bit pseudo-LRU tree per set picks the victim. Bit 0 selects pair {0,1} when 0 or pair {2,3} when 1. Bit 1 selects within {0,1} and bit 2 within {2,3} (0 picks the lower way). Each access sets the bits on its path to point away from the way used.
- R7: A dirty victim is written back first as a full line, with `mem_we`=1 and `mem_addr` = its old {tag, set, 5'b0}, and the fill follows. A clean victim causes no write.
- R8: `busy` is high from the accepting edge until the response cycle. A `req_valid` presented while `busy` is high is ignored and leaves the cache contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_woff | input | 10 | Page offset bits 11:2 (untranslated) |
| req_wdata | input | 32 | Write word |
| ppn | input | 20 | Physical page number, valid the cycle after acceptance |
| busy | output | 1 | Request in flight; new requests ignored |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Read word, or echoed write word |
| mem_req | output | 1 | Next-level line transfer request |
| mem_we | output | 1 | 1 = writeback, 0 = refill |
| mem_addr | output | 32 | Line-aligned physical address |
| mem_wdata | output | 256 | Victim line for writeback |
| mem_ack | input | 1 | One-cycle transfer completion |
| mem_rdata | input | 256 | Refill line, valid with mem_ack |

## Verification
A hit answers two cycles after the accepting edge. A miss answers one cycle after the final `mem_ack`, and the bench's memory model acknowledges on the third cycle of each request, so a clean miss answers five cycles after acceptance. The bench drives inputs on falling edges and then waits falling edge by falling edge until `resp_valid` is seen. It compares that count with the expected latency, and it also compares the number of refills and writebacks the model served. The page number is driven with a wrong value during the accepting cycle, and the offset is corrupted afterwards, so only the cycles where each field is due can produce the right answer.

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int ADDR_W = 32,
  parameter int PAGE_BITS = 12,
  parameter int OFF_BITS = 5,
  localparam int TAG_W = ADDR_W - PAGE_BITS,
  localparam int LINE_W = 8 << OFF_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [PAGE_BITS-3:0] req_woff,
  input  logic [31:0]          req_wdata,
  input  logic [TAG_W-1:0]     ppn,
  output logic                 busy,
  output logic                 resp_valid,
  output logic [31:0]          resp_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LINE_W-1:0]    mem_wdata,
  input  logic                 mem_ack,
  input  logic [LINE_W-1:0]    mem_rdata
);
  localparam int IDX_W = PAGE_BITS - OFF_BITS;
  localparam int SETS = 1 << IDX_W;
  localparam int WSEL_W = OFF_BITS - 2;
  localparam int WAYS = 4;

  typedef enum logic [1:0] {IDLE, LOOK, WB, FILL} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   dty_q  [SETS];
  logic [2:0]        plru_q [SETS];

  logic [IDX_W-1:0]  q_idx;
  logic [WSEL_W-1:0] q_word;
  logic              q_we;
  logic [31:0]       q_wdata;
  logic [TAG_W-1:0]  q_tag;
  logic [1:0]        q_way;

  logic [WAYS-1:0]   hit_vec;
  logic              hit;
  logic [1:0]        hit_way, victim;
  logic [LINE_W-1:0] hit_line;

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [WSEL_W-1:0] w,
                                                 input logic [31:0] d);
    put_word = l;
    put_word[{w, 5'b0} +: 32] = d;
  endfunction

  function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
    touch = t;
    touch[0] = ~w[1];
    if (!w[1]) touch[1] = ~w[0];
    else       touch[2] = ~w[0];
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[q_idx][w] && (tag_q[q_idx][w] == ppn);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) if (hit_vec[i]) hit_way = 2'(i);
  end

  always_comb begin
    victim = plru_q[q_idx][0] ? {1'b1, plru_q[q_idx][2]} : {1'b0, plru_q[q_idx][1]};
    for (int i = WAYS - 1; i >= 0; i--) if (!vld_q[q_idx][i]) victim = 2'(i);
  end

  assign hit_line  = data_q[q_idx][hit_way];
  assign busy      = (st != IDLE);
  assign mem_req   = (st == WB) || (st == FILL);
  assign mem_we    = (st == WB);
  assign mem_addr  = {(st == WB) ? tag_q[q_idx][q_way] : q_tag, q_idx, {OFF_BITS{1'b0}}};
  assign mem_wdata = data_q[q_idx][q_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      resp_valid <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        dty_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) st <= LOOK;
        LOOK: begin
          if (hit) begin
            resp_valid <= 1'b1;
            plru_q[q_idx] <= touch(plru_q[q_idx], hit_way);
            if (q_we) dty_q[q_idx][hit_way] <= 1'b1;
            st <= IDLE;
          end else begin
            st <= (vld_q[q_idx][victim] && dty_q[q_idx][victim]) ? WB : FILL;
          end
        end
        WB: if (mem_ack) st <= FILL;
        FILL: if (mem_ack) begin
          vld_q[q_idx][q_way] <= 1'b1;
          dty_q[q_idx][q_way] <= q_we;
          plru_q[q_idx] <= touch(plru_q[q_idx], q_way);
          resp_valid <= 1'b1;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && req_valid) begin
      q_idx   <= req_woff[PAGE_BITS-3 -: IDX_W];
      q_word  <= req_woff[WSEL_W-1:0];
      q_we    <= req_we;
      q_wdata <= req_wdata;
    end
    if (st == LOOK) begin
      q_tag <= ppn;
      q_way <= victim;
      if (hit) begin
        resp_rdata <= q_we ? q_wdata : hit_line[{q_word, 5'b0} +: 32];
        if (q_we) data_q[q_idx][hit_way] <= put_word(hit_line, q_word, q_wdata);
      end
    end
    if (st == FILL && mem_ack) begin
      tag_q[q_idx][q_way]  <= q_tag;
      data_q[q_idx][q_way] <= q_we ? put_word(mem_rdata, q_word, q_wdata) : mem_rdata;
      resp_rdata <= q_we ? q_wdata : mem_rdata[{q_word, 5'b0} +: 32];
    end
  end
endmodule

// File: rtl/dcache_props.sv
module dcache_props #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              resp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !resp_valid && !mem_req));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  assert_fill_then_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> resp_valid);

  assert_resp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_wb_before_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  assert_miss_after_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(busy));

  assert_no_resp_in_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !mem_req);
endmodule

bind vipt_dcache dcache_props #(.ADDR_W(ADDR_W)) u_props (
  .clk(clk), .rst_n(rst_n), .busy(busy), .resp_valid(resp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_vipt_dcache.sv
module sim_vipt_dcache;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, req_valid, req_we, busy, resp_valid, mem_req, mem_we, mem_ack;
  logic [9:0]   req_woff;
  logic [31:0]  req_wdata, resp_rdata, mem_addr;
  logic [19:0]  ppn;
  logic [255:0] mem_wdata, mem_rdata;

  vipt_dcache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_woff(req_woff), .req_wdata(req_wdata), .ppn(ppn), .busy(busy),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0, rd_ops = 0, wr_ops = 0, op_seq = 0, wb_seq = 0, fill_seq = 0;
  bit done = 0;
  logic [31:0]  last_fill, last_wb;
  logic [255:0] mem_m [int unsigned];
  logic [31:0]  ref_m [int unsigned];

  function automatic logic [31:0] init_word(logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'hC0DE0000;
  endfunction

  function automatic logic [255:0] mem_line(logic [31:0] a);
    logic [255:0] l;
    if (mem_m.exists(a >> 5)) return mem_m[a >> 5];
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = init_word({a[31:5], 3'(i), 2'b00});
    return l;
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] a);
    if (ref_m.exists(a >> 2)) return ref_m[a >> 2];
    return init_word(a);
  endfunction

  function automatic logic [31:0] mk(logic [19:0] t, int s, int w);
    return {t, 7'(s), 3'(w), 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // next-level memory: acknowledges on the third cycle of a request
  initial begin
    int cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        cnt++;
        if (cnt == 3) begin
          op_seq++;
          if (mem_we) begin
            mem_m[mem_addr >> 5] = mem_wdata;
            wr_ops++; last_wb = mem_addr; wb_seq = op_seq;
          end else begin
            mem_rdata = mem_line(mem_addr);
            rd_ops++; last_fill = mem_addr; fill_seq = op_seq;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input bit intrude, input logic [31:0] ia,
                        output logic [31:0] rd, output int lat, output int nr, output int nw);
    int r0 = rd_ops, w0 = wr_ops;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_woff = a[11:2]; req_wdata = wd;
    ppn = ~a[31:12];
    @(negedge clk);
    req_valid = 1'b0; ppn = a[31:12]; req_woff = ~a[11:2];
    lat = 1;
    while (!resp_valid && lat < 2000) begin
      if (intrude) begin
        req_valid = mem_req; req_we = 1'b1; req_woff = ia[11:2]; req_wdata = 32'hBAD0BAD0;
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    rd = resp_rdata;
    nr = rd_ops - r0;
    nw = wr_ops - w0;
  endtask

  task automatic rd_chk(input logic [31:0] a, input string rq, output int lat, output int nr, output int nw);
    logic [31:0] d;
    access(1'b0, a, 32'h0, 1'b0, 32'h0, d, lat, nr, nw);
    chk(d == ref_word(a), rq, d, ref_word(a));
  endtask

  task automatic wr_chk(input logic [31:0] a, input logic [31:0] wd, input string rq,
                        output int lat, output int nr, output int nw);
    logic [31:0] d;
    access(1'b1, a, wd, 1'b0, 32'h0, d, lat, nr, nw);
    ref_m[a >> 2] = wd;
    chk(d == wd, rq, d, wd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat, nr, nw;
    logic [31:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_woff = '0; req_wdata = '0; ppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 busy after reset", 32'(busy), 32'h0);
    chk(!resp_valid, "R1 resp after reset", 32'(resp_valid), 32'h0);
    chk(!mem_req, "R1 mem_req after reset", 32'(mem_req), 32'h0);

    // cold read miss
    rd_chk(mk(20'h12345, 5, 3), "R4 refill data", lat, nr, nw);
    chk(nr == 1 && nw == 0, "R1 cold miss traffic", 32'(nr*16 + nw), 32'h10);
    chk(lat == 5, "R4 miss latency", 32'(lat), 32'd5);
    chk(last_fill == {20'h12345, 7'd5, 5'd0}, "R2 refill address", last_fill, {20'h12345, 7'd5, 5'd0});

    // hit in the same line
    rd_chk(mk(20'h12345, 5, 7), "R2 word select", lat, nr, nw);
    chk(lat == 2, "R3 hit latency", 32'(lat), 32'd2);
    chk(nr == 0 && nw == 0, "R3 hit traffic", 32'(nr*16 + nw), 32'h0);

    // write hit, then every word of the line
    wr_chk(mk(20'h12345, 5, 6), 32'hA5A50006, "R5 write echo", lat, nr, nw);
    chk(lat == 2 && nr == 0 && nw == 0, "R5 write hit no traffic", 32'(lat*256 + nr*16 + nw), 32'h200);
    for (int w = 0; w < 8; w++) rd_chk(mk(20'h12345, 5, w), "R2 line sweep", lat, nr, nw);

    // write miss allocates
    wr_chk(mk(20'h00ABC, 9, 1), 32'h11112222, "R5 write miss echo", lat, nr, nw);
    chk(nr == 1 && nw == 0, "R5 allocate fill", 32'(nr*16 + nw), 32'h10);
    for (int w = 0; w < 8; w++) rd_chk(mk(20'h00ABC, 9, w), "R5 merged line", lat, nr, nw);

    // replacement order
    for (int t = 0; t < 4; t++) rd_chk(mk(20'(100 + t), 20, 0), "R6 fill ways", lat, nr, nw);
    rd_chk(mk(20'd100, 20, 0), "R6 touch A", lat, nr, nw);
    chk(nr == 0, "R6 A hits", 32'(nr), 32'h0);
    rd_chk(mk(20'd104, 20, 0), "R6 new tag", lat, nr, nw);
    chk(nr == 1 && nw == 0, "R7 clean victim no write", 32'(nr*16 + nw), 32'h10);
    rd_chk(mk(20'd101, 20, 2), "R6 B kept", lat, nr, nw);
    chk(nr == 0, "R6 B hits", 32'(nr), 32'h0);
    rd_chk(mk(20'd103, 20, 2), "R6 D kept", lat, nr, nw);
    chk(nr == 0, "R6 D hits", 32'(nr), 32'h0);
    rd_chk(mk(20'd100, 20, 2), "R6 A kept", lat, nr, nw);
    chk(nr == 0, "R6 A still hits", 32'(nr), 32'h0);
    rd_chk(mk(20'd102, 20, 0), "R6 C evicted", lat, nr, nw);
    chk(nr == 1, "R6 C misses", 32'(nr), 32'h1);

    // dirty writeback
    wr_chk(mk(20'd300, 33, 4), 32'hDEADBEEF, "R7 dirty write", lat, nr, nw);
    for (int t = 1; t < 4; t++) rd_chk(mk(20'(300 + t), 33, 0), "R7 fill set", lat, nr, nw);
    rd_chk(mk(20'd310, 33, 0), "R7 evicting read", lat, nr, nw);
    chk(nr == 1 && nw == 1, "R7 writeback and fill", 32'(nr*16 + nw), 32'h11);
    chk(last_wb == {20'd300, 7'd33, 5'd0}, "R7 writeback address", last_wb, {20'd300, 7'd33, 5'd0});
    chk(wb_seq < fill_seq, "R7 writeback first", 32'(wb_seq), 32'(fill_seq));
    rd_chk(mk(20'd300, 33, 4), "R7 written data survives", lat, nr, nw);
    chk(nr == 1, "R7 refetch miss", 32'(nr), 32'h1);

    // requests while busy are ignored
    access(1'b0, mk(20'h0F0F0, 40, 0), 32'h0, 1'b1, mk(20'h12345, 5, 0), d, lat, nr, nw);
    chk(d == ref_word(mk(20'h0F0F0, 40, 0)), "R8 busy access data", d, ref_word(mk(20'h0F0F0, 40, 0)));
    chk(lat == 5 && nr == 1, "R8 single transfer", 32'(lat*16 + nr), 32'h51);
    repeat (3) begin
      @(negedge clk);
      chk(!resp_valid && !busy, "R8 no extra response", 32'(resp_valid), 32'h0);
    end
    rd_chk(mk(20'h12345, 5, 0), "R8 target unchanged", lat, nr, nw);
    chk(nr == 0, "R8 target still hits", 32'(nr), 32'h0);

    // sweep: six tags into sets spread over the index range
    for (int s = 0; s < 128; s += 7)
      for (int t = 0; t < 6; t++)
        wr_chk(mk(20'(200 + t), s, (t + s) % 8), 32'(s * 1000 + t) ^ 32'h5EED0000, "R5 sweep write", lat, nr, nw);
    for (int s = 0; s < 128; s += 7)
      for (int t = 0; t < 6; t++) begin
        rd_chk(mk(20'(200 + t), s, (t + s) % 8), "R7 sweep readback", lat, nr, nw);
        rd_chk(mk(20'(200 + t), s, (t + s + 1) % 8), "R4 sweep neighbour", lat, nr, nw);
      end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule